// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that completes every instruction in one clock cycle. It runs a nine-instruction subset: word load and store, the register-to-register operations add, subtract, and, or and set-on-less-than, an equality branch and an absolute jump. The core holds the program counter, a 32-entry register file, the ALU, and separate instruction and data memories. Because the two memories are separate, a load or store never competes with instruction fetch.

Decoding has two levels. A main decoder turns the 6-bit opcode into single-bit datapath controls and a 2-bit class code. A second decoder combines that class code with the function field and produces the 3-bit ALU operation. A preload port fills either memory while the core is held in reset. A trace of the register-file write, the data-memory write and the program counter lets a surrounding environment compare the core against an instruction-level model.

Top module: `sc_core`

## Requirements
- R1: `pc_o` is 0 while `rst_ni` is low. After reset it advances by 4 on each rising edge unless a branch is taken or a jump executes.
- R2: R-format instructions (opcode 0; fields opcode[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0]) write rd with rs+rt (funct 32), rs-rt (funct 34), rs AND rt (funct 36) or rs OR rt (funct 37), each modulo 2^32.
- R3: Funct 42 writes rd with 1 when rs is less than rt as two's-complement numbers, and 0 otherwise.
- R4: A load (opcode 35) reads the data word at base rs plus the sign-extended immediate[15:0] and writes it to rt. The word index is address bits [9:2].
- R5: A store (opcode 43) writes rt to the data word at rs plus the sign-extended immediate, and writes no register.
- R6: The branch (opcode 4) compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4. Backward offsets are allowed.
- R7: The jump (opcode 2) sets the PC to {PC+4[31:28], instr[25:0], 00}.
- R8: Register 0 always reads as zero. A write addressed to it is discarded, and `rf_we_o` stays low for it.
- R9: With `ld_en_i` high, the word `ld_data_i` is written at index `ld_addr_i` on the rising edge. The target is the data memory when `ld_dmem_i` is 1 and the instruction memory otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of PC and registers |
| ld_en_i | input | 1 | Preload write enable |
| ld_dmem_i | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr_i | input | 8 | Preload word index |
| ld_data_i | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write in this cycle (never for register 0) |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written |
| dm_we_o | output | 1 | Data-memory store in this cycle |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
Assertions check several properties on every cycle: the PC steps by 4 on sequential instructions, lands on the computed target after a taken branch or a jump, and never combines a store with a register write; register 0 always reads zero. Arithmetic results, signed comparison, load data, address wrap with negative offsets, discarded writes to register 0, and a backward-branch loop with both branch outcomes can only be shown by running programs. For this the bench runs a randomized program and compares each cycle's trace against its own instruction-level model.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_J     = 6'd2;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    CLS_MEM   = 2'b00,
    CLS_BR    = 2'b01,
    CLS_FUNCT = 2'b10
  } op_class_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic      dst_rd;
    logic      b_imm;
    logic      wb_mem;
    logic      reg_wr;
    logic      mem_rd;
    logic      mem_wr;
    logic      branch;
    logic      jump;
    op_class_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_core_pkg::*;
(
  input  logic [5:0] op_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{dst_rd: 1'b0, b_imm: 1'b0, wb_mem: 1'b0, reg_wr: 1'b0,
               mem_rd: 1'b0, mem_wr: 1'b0, branch: 1'b0, jump: 1'b0,
               cls: CLS_MEM};
    case (op_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.cls    = CLS_FUNCT;
      end
      OP_LW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.cls    = CLS_BR;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_core_pkg::*;
(
  input  op_class_e  cls_i,
  input  logic [5:0] funct_i,
  output alu_op_e    op_o
);
  always_comb begin
    case (cls_i)
      CLS_MEM: op_o = ALU_ADD;
      CLS_BR:  op_o = ALU_SUB;
      default: begin
        case (funct_i)
          FN_SUB:  op_o = ALU_SUB;
          FN_AND:  op_o = ALU_AND;
          FN_OR:   op_o = ALU_OR;
          FN_SLT:  op_o = ALU_SLT;
          default: op_o = ALU_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_a_i,
  input  logic [RAW-1:0]  ra_b_i,
  output logic [XLEN-1:0] rd_a_o,
  output logic [XLEN-1:0] rd_b_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : regs[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs[ra_b_i];

  // R8
  r0_read_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_a_i == '0) |-> (rd_a_o == '0));
  // R8
  r0_read_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_b_i == '0) |-> (rd_b_o == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_en_i,
  input  logic            ld_dmem_i,
  input  logic [LAW-1:0]  ld_addr_i,
  input  logic [XLEN-1:0] ld_data_i,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] pc, pc_plus4, br_tgt, j_tgt, pc_next;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, rd_data, wb_data;
  logic [4:0]      wa;
  logic            alu_zero;
  ctrl_t           ctrl;
  alu_op_e         alu_op;

  always_ff @(posedge clk_i) begin
    if (ld_en_i && !ld_dmem_i) imem[ld_addr_i[IAW-1:0]] <= ld_data_i;
  end

  assign instr   = imem[pc[IAW+1:2]];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_main_dec u_dec (.op_i(instr[31:26]), .ctrl_o(ctrl));

  sc_alu_ctrl u_actl (.cls_i(ctrl.cls), .funct_i(instr[5:0]), .op_o(alu_op));

  assign wa = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.XLEN(XLEN), .NREGS(32)) u_rf (
    .clk_i, .rst_ni,
    .ra_a_i(instr[25:21]), .ra_b_i(instr[20:16]),
    .rd_a_o(rs_val), .rd_b_o(rt_val),
    .we_i(ctrl.reg_wr), .wa_i(wa), .wd_i(wb_data)
  );

  assign alu_b = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a_i(rs_val), .b_i(alu_b), .op_i(alu_op), .y_o(alu_y), .zero_o(alu_zero)
  );

  // Harvard data memory: combinational read, store on rising edge
  assign rd_data = ctrl.mem_rd ? dmem[alu_y[DAW+1:2]] : '0;
  assign wb_data = ctrl.wb_mem ? rd_data : alu_y;

  always_ff @(posedge clk_i) begin
    if (ld_en_i && ld_dmem_i) dmem[ld_addr_i[DAW-1:0]] <= ld_data_i;
    else if (rst_ni && ctrl.mem_wr) dmem[alu_y[DAW+1:2]] <= rt_val;
  end

  // Next-PC selection
  assign pc_plus4 = pc + XLEN'(4);
  assign br_tgt   = pc_plus4 + (imm_ext << 2);
  assign j_tgt    = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
  always_comb begin
    if (ctrl.jump)                  pc_next = j_tgt;
    else if (ctrl.branch && alu_zero) pc_next = br_tgt;
    else                            pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc <= '0;
    else         pc <= pc_next;
  end

  assign pc_o       = pc;
  assign rf_we_o    = ctrl.reg_wr && (wa != 5'd0);
  assign rf_waddr_o = wa;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = ctrl.mem_wr;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc[1:0], alu_y[1:0]};

  // R1
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.jump && !(ctrl.branch && rs_val == rt_val)) |=> (pc == $past(pc) + XLEN'(4)));
  // R6
  beq_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.branch && rs_val == rt_val) |=> (pc == $past(br_tgt)));
  // R7
  jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |=> (pc == $past(j_tgt)));
  // R5
  store_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_o |-> !rf_we_o);
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_en_i = 1'b0, ld_dmem_i = 1'b0;
  logic [7:0]  ld_addr_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int n_tests = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  sc_core uut (.*);

  logic [31:0] m_im [256];
  logic [31:0] m_dm [256];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;
  int          plen;

  logic        e_we, e_dwe;
  logic [4:0]  e_wa;
  logic [31:0] e_wd, e_daddr, e_dwd, e_npc;

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_ins(int widx);
    return {6'd2, 26'(widx)};
  endfunction

  function automatic string req_of(logic [31:0] ins);
    case (ins[31:26])
      6'd0:    return (ins[15:11] == 5'd0) ? "R8" : (ins[5:0] == 6'd42) ? "R3" : "R2";
      6'd35:   return (ins[20:16] == 5'd0) ? "R8" : "R4";
      6'd43:   return "R5";
      6'd4:    return "R6";
      6'd2:    return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic emit(logic [31:0] ins);
    m_im[plen] = ins;
    plen++;
  endtask

  // instruction-level model of the current instruction
  task automatic model_eval();
    logic [31:0] ins, rs, rt, imm, p4;
    ins = m_im[m_pc[9:2]];
    rs  = m_rf[ins[25:21]];
    rt  = m_rf[ins[20:16]];
    imm = {{16{ins[15]}}, ins[15:0]};
    p4  = m_pc + 32'd4;
    e_we = 1'b0; e_wa = '0; e_wd = '0; e_dwe = 1'b0; e_daddr = '0; e_dwd = '0;
    e_npc = p4;
    case (ins[31:26])
      6'd0: begin
        e_wa = ins[15:11];
        e_we = (e_wa != 0);
        case (ins[5:0])
          6'd34:   e_wd = rs - rt;
          6'd36:   e_wd = rs & rt;
          6'd37:   e_wd = rs | rt;
          6'd42:   e_wd = ($signed(rs) < $signed(rt)) ? 32'd1 : 32'd0;
          default: e_wd = rs + rt;
        endcase
      end
      6'd35: begin
        e_wa = ins[20:16];
        e_we = (e_wa != 0);
        e_wd = m_dm[(rs + imm) >> 2 & 32'hFF];
      end
      6'd43: begin
        e_dwe = 1'b1; e_daddr = rs + imm; e_dwd = rt;
      end
      6'd4: if (rs == rt) e_npc = p4 + (imm << 2);
      6'd2: e_npc = {p4[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
  endtask

  task automatic model_commit();
    if (e_we) m_rf[e_wa] = e_wd;
    if (e_dwe) m_dm[e_daddr[9:2]] = e_dwd;
    m_pc = e_npc;
  endtask

  task automatic build_program();
    int loop_at, skip_at;
    logic [5:0] fns [5];
    fns[0] = 6'd32; fns[1] = 6'd34; fns[2] = 6'd36; fns[3] = 6'd37; fns[4] = 6'd42;
    for (int i = 0; i < 256; i++) m_im[i] = i_ins(6'd4, 0, 0, -1);  // halt: self branch
    plen = 0;
    // R4: load seeds r1..r8
    for (int i = 0; i < 8; i++) emit(i_ins(6'd35, 0, i + 1, 4 * i));
    // R2/R3: random register operations, r0 included as destination
    for (int i = 0; i < 40; i++)
      emit(r_ins($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                 fns[$urandom_range(0, 4)]));
    // R3 directed signed compare: negative vs positive
    emit(r_ins(0, 1, 9, 6'd34));        // r9 = -r1
    emit(r_ins(9, 1, 10, 6'd42));
    emit(r_ins(1, 9, 11, 6'd42));
    // R8: write to r0 then store it
    emit(r_ins(1, 2, 0, 6'd32));
    emit(i_ins(6'd43, 0, 0, 4 * 100));
    // R5: store r1..r15
    for (int k = 1; k < 16; k++) emit(i_ins(6'd43, 0, k, 4 * (64 + k)));
    // R6: counted loop with backward branch
    emit(i_ins(6'd35, 0, 21, 4 * 16));
    emit(i_ins(6'd35, 0, 22, 4 * 17));
    emit(r_ins(20, 20, 20, 6'd34));
    loop_at = plen;
    emit(r_ins(20, 21, 20, 6'd32));
    emit(r_ins(20, 22, 23, 6'd42));
    emit(i_ins(6'd4, 23, 0, 1));
    emit(i_ins(6'd4, 0, 0, loop_at - plen - 1));
    emit(i_ins(6'd43, 0, 20, 4 * 200));
    // R7: jump over one instruction
    skip_at = plen + 2;
    emit(j_ins(skip_at));
    emit(r_ins(1, 1, 24, 6'd32));
    // R4: negative offset wraps to the top word
    emit(i_ins(6'd35, 21, 25, -4));
    emit(i_ins(6'd43, 21, 25, -8));
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    string prev_req;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) m_dm[i] = $urandom();
    m_dm[16] = 32'd1;
    m_dm[17] = 32'd3;
    m_dm[0]  = 32'h8000_0000;
    m_dm[1]  = 32'h7FFF_FFFF;
    build_program();
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_pc = '0;

    // R9: preload both memories under reset
    @(negedge clk_i);
    for (int i = 0; i < 512; i++) begin
      ld_en_i   = 1'b1;
      ld_dmem_i = (i >= 256);
      ld_addr_i = 8'(i);
      ld_data_i = (i >= 256) ? m_dm[i - 256] : m_im[i];
      @(negedge clk_i);
    end
    ld_en_i = 1'b0;
    // R1: reset value
    check("R1", pc_o, 32'd0, "pc in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_req = "R1";
    for (int c = 0; c < 220; c++) begin
      #1;
      model_eval();
      check(prev_req, pc_o, m_pc, "pc");
      check(req_of(m_im[m_pc[9:2]]), {31'd0, rf_we_o}, {31'd0, e_we}, "rf_we");
      if (e_we) begin
        check(req_of(m_im[m_pc[9:2]]), {27'd0, rf_waddr_o}, {27'd0, e_wa}, "rf_waddr");
        check(req_of(m_im[m_pc[9:2]]), rf_wdata_o, e_wd, "rf_wdata");
      end
      check("R5", {31'd0, dm_we_o}, {31'd0, e_dwe}, "dm_we");
      if (e_dwe) begin
        check("R5", dm_addr_o, e_daddr, "dm_addr");
        check(req_of(m_im[m_pc[9:2]]) == "R5" && e_daddr == 32'd400 ? "R8" : "R5",
              dm_wdata_o, e_dwd, "dm_wdata");
      end
      prev_req = (m_im[m_pc[9:2]][31:26] == 6'd4) ? "R6" :
                 (m_im[m_pc[9:2]][31:26] == 6'd2) ? "R7" : "R1";
      model_commit();
      @(negedge clk_i);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule